// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a parameterised set of shared interrupt inputs (a multiple of eight, up to 256) and turns them into interrupt lines, one per output pin per processor. Each source is conditioned on its own: a polarity bit, a level-or-edge bit and a both-edges bit decide what counts as active. Edge-triggered sources keep a capture latch that software acknowledges, and software can also set that latch to raise an interrupt between processors.

Software reaches every setting through a simple word-addressed register bus. A write is strobed by `bus_wr` and takes effect at the next rising clock. A read is combinational from `bus_addr`. Each source has a mask bit, changed one source at a time through write-only set and clear registers. It also has a pin map, holding an enable bit and a pin number, and a processor map holding a one-hot processor select. A pending readout shows the conditioned state of every source.

The register layout uses word addresses. 0x000 is the read-only configuration word. 0x001 sets a mask bit, 0x002 clears a mask bit and 0x003 is the edge-write register. Polarity words sit at 0x010+w, trigger words at 0x020+w, both-edge words at 0x030+w and pending words at 0x040+w. Source s has its pin map at 0x100+s and its processor map at 0x200+s. Word w holds sources 32w to 32w+31, with source s at bit s%32.

There is no sequencing state machine. The only registered state is the per-source input sample, the per-source capture latch and the configuration registers.

Top module: `shint_ctrl`

## Requirements
- R1: After reset, every source is active-high (polarity bit 1), level-triggered (trigger bit 0), single-edge (both-edge bit 0) and masked. Every pin map is disabled, every processor map is zero and `irq_out` is all zero. The configuration word at 0x000 reads N = NUM_SRC/8-1 in bits [7:0].
- R2: A level source (trigger 0) shows pending equal to its input when polarity is 1, and to the inverted input when polarity is 0, one clock after the input changes.
- R3: An edge source (trigger 1, both-edge 0) sets its capture latch on a rising input edge when polarity is 1 and on a falling edge when polarity is 0. The latch holds after the input returns, and pending shows the latch.
- R4: An edge source with both-edge set to 1 captures rising and falling edges alike, whatever its polarity. For a level source the both-edge bit has no effect.
- R5: Writing index i (wdata[7:0]) to 0x001 unmasks source i and writing it to 0x002 masks it, from the next clock. The other sources' mask bits are unchanged, and an index of NUM_SRC or more changes nothing.
- R6: A write to 0x003 with wdata[31]=1 sets the capture latch of source wdata[7:0]. With wdata[31]=0 it clears that latch. An edge detected in the same cycle as a clear wins, so the latch stays set.
- R7: Pending word w at 0x040+w shows source s at bit s%32 of word s/32. It reflects an input one clock after the input changes, and words past ceil(NUM_SRC/32) read zero.
- R8: `irq_out[c*NUM_PIN+p]` is high exactly when some source meets all of the following: it is pending and unmasked, its pin map has bit 31 (enable) set and bits [PIN_W-1:0] equal to p, and bit c of its processor map is set.
- R9: The polarity, trigger and both-edge words, the pin map at 0x100+s and the processor map at 0x200+s (bits [NUM_CPU-1:0]) read back what was written. Data bits for sources or fields that do not exist are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NUM_SRC | Raw shared interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_out | output | NUM_CPU*NUM_PIN | Interrupt lines, index c*NUM_PIN+p |

## Verification
The bench sweeps all eight combinations of polarity, trigger and both-edge on one source through a fixed input sequence, and compares each step with an arithmetic model. A design that swapped polarity on edges, honoured both-edge on a level source or dropped a latch after the input returned would give the wrong pending bit. It also drives an edge and an acknowledge in the same cycle, where a clear-priority latch would lose the interrupt. Masks are set and then cleared one index at a time with all inputs high, and out-of-range indices are written. The expected interrupt lines are computed from the bench's own map tables, so a routing slip, a mask write that reached a neighbouring source or a wrapped index shows up on `irq_out`.

// File: rtl/shint_pkg.sv
package shint_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 8;

    // Decoded register region of the current bus address
    typedef enum logic [3:0] {
        REG_NONE,
        REG_CFG,
        REG_SMASK,
        REG_RMASK,
        REG_EDGE,
        REG_POL,
        REG_TRIG,
        REG_DUAL,
        REG_PEND,
        REG_PINMAP,
        REG_CPUMAP
    } reg_sel_e;

endpackage

// File: rtl/shint_src.sv
module shint_src (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    input  logic pol_i,
    input  logic trig_i,
    input  logic dual_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    output logic pend_o
);
    logic in_q;
    logic latch_q;
    logic arm_q;
    logic rise;
    logic fall;
    logic hit;

    assign rise = in_i & ~in_q;
    assign fall = ~in_i & in_q;
    assign hit  = trig_i & (dual_i ? (rise | fall) : (pol_i ? rise : fall));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q    <= 1'b0;
            latch_q <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            in_q  <= in_i;
            arm_q <= 1'b1;
            if (hit || sw_set_i)
                latch_q <= 1'b1;
            else if (sw_clr_i)
                latch_q <= 1'b0;
        end
    end

    assign pend_o = trig_i ? latch_q : (pol_i ? in_q : ~in_q);

    assert_ipi_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_i |=> latch_q);

    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !sw_clr_i) |=> latch_q);

    assert_level_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && !trig_i) |-> (pend_o == (pol_i ? $past(in_i) : !$past(in_i))));

endmodule

// File: rtl/shint_route.sv
module shint_route #(
    parameter int NUM_SRC = 16,
    parameter int NUM_CPU = 2,
    parameter int NUM_PIN = 4,
    parameter int PIN_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                pend_i,
    input  logic [NUM_SRC-1:0]                mask_i,
    input  logic [NUM_SRC-1:0]                map_en_i,
    input  logic [NUM_SRC-1:0][PIN_W-1:0]     pin_i,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0]   cpu_i,
    output logic [NUM_CPU*NUM_PIN-1:0]        irq_o
);
    logic [NUM_SRC-1:0] act;
    assign act = pend_i & mask_i & map_en_i;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            logic acc;
            always_comb begin
                acc = 1'b0;
                for (int s = 0; s < NUM_SRC; s++)
                    acc = acc | (act[s] & cpu_i[s][c] & (pin_i[s] == PIN_W'(p)));
            end
            assign irq_o[c*NUM_PIN+p] = acc;
        end
    end

    assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & mask_i) == '0) |-> (irq_o == '0));

    assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (map_en_i == '0) |-> (irq_o == '0));

endmodule

// File: rtl/shint_ctrl.sv
module shint_ctrl
    import shint_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_CPU = 2,
    parameter int NUM_PIN = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_in,
    input  logic                       bus_wr,
    input  logic [9:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic [NUM_CPU*NUM_PIN-1:0] irq_out
);
    localparam int NW     = (NUM_SRC + 31) / 32;
    localparam int PIN_W  = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int WID_W  = (NW > 1) ? $clog2(NW) : 1;
    localparam int CFG_N  = NUM_SRC / 8 - 1;
    localparam logic [8:0] SRC_LIM = 9'(NUM_SRC);
    localparam logic [4:0] NW_LIM  = 5'(NW);

    logic [NUM_SRC-1:0]              pol_q, trig_q, dual_q, mask_q, pin_en_q;
    logic [NUM_SRC-1:0][PIN_W-1:0]   pin_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] cpu_q;
    logic [NUM_SRC-1:0]              pend;
    logic [NUM_SRC-1:0]              sw_set, sw_clr;

    reg_sel_e          reg_sel;
    logic [3:0]        widx;
    logic [IDX_W-1:0]  sidx;
    logic              widx_ok, sidx_ok, widx_idx_ok;
    logic [IDX_W-1:0]  wr_idx;
    logic              wr_idx_ok;
    logic [WID_W-1:0]  widx_t;
    logic [SRC_W-1:0]  sidx_t;

    // Address decode
    always_comb begin
        reg_sel = REG_NONE;
        unique case (bus_addr[9:8])
            2'd0: begin
                unique case (bus_addr[7:4])
                    4'h0: begin
                        unique case (bus_addr[3:0])
                            4'h0:    reg_sel = REG_CFG;
                            4'h1:    reg_sel = REG_SMASK;
                            4'h2:    reg_sel = REG_RMASK;
                            4'h3:    reg_sel = REG_EDGE;
                            default: reg_sel = REG_NONE;
                        endcase
                    end
                    4'h1:    reg_sel = REG_POL;
                    4'h2:    reg_sel = REG_TRIG;
                    4'h3:    reg_sel = REG_DUAL;
                    4'h4:    reg_sel = REG_PEND;
                    default: reg_sel = REG_NONE;
                endcase
            end
            2'd1:    reg_sel = REG_PINMAP;
            2'd2:    reg_sel = REG_CPUMAP;
            default: reg_sel = REG_NONE;
        endcase
    end

    assign widx      = bus_addr[3:0];
    assign sidx      = bus_addr[7:0];
    assign widx_ok   = ({1'b0, widx} < NW_LIM);
    assign sidx_ok   = ({1'b0, sidx} < SRC_LIM);
    assign widx_t    = widx[WID_W-1:0];
    assign sidx_t    = sidx[SRC_W-1:0];
    assign wr_idx    = bus_wdata[IDX_W-1:0];
    assign wr_idx_ok = ({1'b0, wr_idx} < SRC_LIM);
    assign widx_idx_ok = widx_ok;

    // Edge-write strobes: bit 31 selects set (software interrupt) or clear (acknowledge)
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            sw_set[s] = bus_wr && (reg_sel == REG_EDGE) && (wr_idx == IDX_W'(s)) &&  bus_wdata[31];
            sw_clr[s] = bus_wr && (reg_sel == REG_EDGE) && (wr_idx == IDX_W'(s)) && !bus_wdata[31];
        end
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q    <= '1;
            trig_q   <= '0;
            dual_q   <= '0;
            mask_q   <= '0;
            pin_en_q <= '0;
            pin_q    <= '0;
            cpu_q    <= '0;
        end else if (bus_wr) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (widx == 4'(s / 32)) begin
                    if (reg_sel == REG_POL)  pol_q[s]  <= bus_wdata[s % 32];
                    if (reg_sel == REG_TRIG) trig_q[s] <= bus_wdata[s % 32];
                    if (reg_sel == REG_DUAL) dual_q[s] <= bus_wdata[s % 32];
                end
                if (wr_idx == IDX_W'(s)) begin
                    if (reg_sel == REG_SMASK) mask_q[s] <= 1'b1;
                    if (reg_sel == REG_RMASK) mask_q[s] <= 1'b0;
                end
                if (sidx == IDX_W'(s)) begin
                    if (reg_sel == REG_PINMAP) begin
                        pin_en_q[s] <= bus_wdata[31];
                        pin_q[s]    <= bus_wdata[PIN_W-1:0];
                    end
                    if (reg_sel == REG_CPUMAP)
                        cpu_q[s] <= bus_wdata[NUM_CPU-1:0];
                end
            end
        end
    end

    // Per-source sense conditioning
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        shint_src u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_i     (src_in[s]),
            .pol_i    (pol_q[s]),
            .trig_i   (trig_q[s]),
            .dual_i   (dual_q[s]),
            .sw_set_i (sw_set[s]),
            .sw_clr_i (sw_clr[s]),
            .pend_o   (pend[s])
        );
    end

    shint_route #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .NUM_PIN (NUM_PIN),
        .PIN_W   (PIN_W)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .mask_i   (mask_q),
        .map_en_i (pin_en_q),
        .pin_i    (pin_q),
        .cpu_i    (cpu_q),
        .irq_o    (irq_out)
    );

    // Read path
    logic [NW-1:0][31:0] pol_w, trig_w, dual_w, pend_w;
    assign pol_w  = (NW*32)'(pol_q);
    assign trig_w = (NW*32)'(trig_q);
    assign dual_w = (NW*32)'(dual_q);
    assign pend_w = (NW*32)'(pend);

    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel)
            REG_CFG:    bus_rdata = 32'(CFG_N);
            REG_POL:    if (widx_idx_ok) bus_rdata = pol_w[widx_t];
            REG_TRIG:   if (widx_idx_ok) bus_rdata = trig_w[widx_t];
            REG_DUAL:   if (widx_idx_ok) bus_rdata = dual_w[widx_t];
            REG_PEND:   if (widx_idx_ok) bus_rdata = pend_w[widx_t];
            REG_PINMAP: if (sidx_ok) bus_rdata = {pin_en_q[sidx_t], {(31-PIN_W){1'b0}}, pin_q[sidx_t]};
            REG_CPUMAP: if (sidx_ok) bus_rdata = 32'(cpu_q[sidx_t]);
            default:    bus_rdata = '0;
        endcase
    end

    assert_smask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && reg_sel == REG_SMASK && wr_idx_ok) |=> mask_q[$past(wr_idx[SRC_W-1:0])]);

    assert_rmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && reg_sel == REG_RMASK && wr_idx_ok) |=> !mask_q[$past(wr_idx[SRC_W-1:0])]);

    assert_bad_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (reg_sel == REG_SMASK || reg_sel == REG_RMASK) && !wr_idx_ok) |=> $stable(mask_q));

endmodule

// File: tb/tb_shint_ctrl.sv
module tb_shint_ctrl;
    localparam int CLK_P   = 10;
    localparam int NSRC    = 16;
    localparam int NCPU    = 2;
    localparam int NPIN    = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NSRC-1:0]      src_in = '0;
    logic                 bus_wr = 1'b0;
    logic [9:0]           bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NCPU*NPIN-1:0] irq_out;

    int checks = 0;
    int errors = 0;

    logic [NSRC-1:0] m_mask = '0;
    logic [NSRC-1:0] m_en   = '0;
    logic [1:0]      m_pin [NSRC];
    logic [1:0]      m_cpu [NSRC];

    shint_ctrl #(.NUM_SRC(NSRC), .NUM_CPU(NCPU), .NUM_PIN(NPIN)) dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] model_irq(input logic [NSRC-1:0] pins);
        logic [7:0] r = '0;
        for (int s = 0; s < NSRC; s++)
            if (pins[s] && m_mask[s] && m_en[s])
                for (int c = 0; c < NCPU; c++)
                    if (m_cpu[s][c]) r[c*NPIN + m_pin[s]] = 1'b1;
        return r;
    endfunction

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [6:0]  seq = 7'b1010011;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_out", 32'(irq_out), 32'h0);
        rd(10'h000, d); chk("R1 cfg N", d, 32'd1);
        rd(10'h010, d); chk("R1 polarity", d, 32'h0000_FFFF);
        rd(10'h020, d); chk("R1 trigger", d, 32'h0);
        rd(10'h030, d); chk("R1 dual", d, 32'h0);
        rd(10'h040, d); chk("R1 pending", d, 32'h0);
        rd(10'h105, d); chk("R1 pin map", d, 32'h0);

        // R7: pending word layout and one-cycle latency
        @(negedge clk);
        src_in = 16'h3C5A;
        rd(10'h040, d); chk("R7 before edge", d, 32'h0);
        step();
        rd(10'h040, d); chk("R7 pending word", d, 32'h0000_3C5A);
        rd(10'h041, d); chk("R7 word beyond count", d, 32'h0);
        src_in = '0;
        step();

        // R2 R3 R4: sweep all sense modes on source 3
        for (int m = 0; m < 8; m++) begin
            logic pol, trg, dul, prev, lat, exp_p;
            pol = m[0]; trg = m[1]; dul = m[2];
            wr(10'h010, 32'h0000_FFF7 | (32'(pol) << 3));
            wr(10'h020, 32'(trg) << 3);
            wr(10'h030, 32'(dul) << 3);
            wr(10'h003, 32'h0000_0003);
            prev = 1'b0; lat = 1'b0;
            for (int i = 0; i < 7; i++) begin
                src_in[3] = seq[i];
                step();
                if (trg) begin
                    if (dul) lat = lat | (seq[i] != prev);
                    else if (pol) lat = lat | (seq[i] & ~prev);
                    else lat = lat | (~seq[i] & prev);
                    exp_p = lat;
                end else begin
                    exp_p = pol ? seq[i] : ~seq[i];
                end
                prev = seq[i];
                rd(10'h040, d);
                chk(trg ? (dul ? "R4 dual edge" : "R3 single edge") : (dul ? "R4 dual ignored on level" : "R2 level"),
                    d, 32'(exp_p) << 3);
            end
            src_in[3] = 1'b0;
            step();
        end
        wr(10'h010, 32'h0000_FFFF);
        wr(10'h020, 32'h0);
        wr(10'h030, 32'h0);
        step();

        // R6: edge-write set / clear, and edge beats clear
        wr(10'h020, 32'h0000_0020);
        wr(10'h003, 32'h8000_0005);
        rd(10'h040, d); chk("R6 software set", d, 32'h0000_0020);
        wr(10'h003, 32'h0000_0005);
        rd(10'h040, d); chk("R6 acknowledge", d, 32'h0);
        src_in[5] = 1'b1; step();
        src_in[5] = 1'b0; step();
        rd(10'h040, d); chk("R3 latch holds", d, 32'h0000_0020);
        wr(10'h003, 32'h0000_0005);
        @(negedge clk);
        src_in[5] = 1'b1;
        bus_wr = 1'b1; bus_addr = 10'h003; bus_wdata = 32'h0000_0005;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        rd(10'h040, d); chk("R6 edge wins over clear", d, 32'h0000_0020);
        wr(10'h003, 32'h0000_0005);
        wr(10'h003, 32'h8000_0014);
        rd(10'h040, d); chk("R6 out-of-range index", d, 32'h0);
        src_in[5] = 1'b0;
        wr(10'h020, 32'h0);
        step();

        // R9 R8: map set-up
        for (int s = 0; s < NSRC; s++) begin
            m_en[s]  = (s != 9);
            m_pin[s] = 2'(s % 4);
            m_cpu[s] = 2'(1 << ((s / 4) % 2));
            wr(10'h100 + 10'(s), {m_en[s], 29'b0, m_pin[s]});
            wr(10'h200 + 10'(s), 32'(m_cpu[s]));
        end
        rd(10'h107, d); chk("R9 pin map readback", d, 32'h8000_0003);
        rd(10'h207, d); chk("R9 cpu map readback", d, 32'h0000_0002);
        wr(10'h010, 32'hFFFF_A5A5);
        rd(10'h010, d); chk("R9 polarity readback", d, 32'h0000_A5A5);
        wr(10'h010, 32'h0000_FFFF);

        // R5: all masked, all inputs high
        src_in = '1;
        step();
        chk("R5 all masked", 32'(irq_out), 32'h0);
        wr(10'h001, 32'h0000_0014);
        chk("R5 bad index no unmask", 32'(irq_out), 32'h0);

        // R8: unmask one at a time, one input at a time
        for (int s = 0; s < NSRC; s++) begin
            @(negedge clk);
            src_in = NSRC'(1) << s;
            bus_wr = 1'b1; bus_addr = 10'h001; bus_wdata = 32'(s);
            @(posedge clk);
            @(negedge clk);
            bus_wr = 1'b0;
            m_mask[s] = 1'b1;
            chk("R8 single route", 32'(irq_out), 32'(model_irq(src_in)));
        end

        // R5: all inputs high, clear masks one by one
        src_in = '1;
        step();
        chk("R8 all routed", 32'(irq_out), 32'(model_irq(src_in)));
        for (int s = 0; s < NSRC; s++) begin
            wr(10'h002, 32'(s));
            m_mask[s] = 1'b0;
            chk("R5 reset-mask leaves others", 32'(irq_out), 32'(model_irq(src_in)));
        end

        // R8: re-route one source to another pin
        wr(10'h001, 32'h0000_0002);
        m_mask[2] = 1'b1;
        wr(10'h102, 32'h8000_0001);
        m_pin[2] = 2'd1;
        chk("R8 pin change", 32'(irq_out), 32'(model_irq(src_in)));
        wr(10'h102, 32'h0000_0001);
        m_en[2] = 1'b0;
        chk("R8 map disabled", 32'(irq_out), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule